// File: doc/BRIEF.md
# Backup Power Sequencer

This block decides when a receiver core may run and when it must sit in a low-power retention state. It runs from the always-on low-frequency timer clock. It watches two board pins: an active-high power-enable pin and an active-low reset pin. From them it produces an oscillator enable, a stall flag for the oscillator and PLL settling window, the core's internal reset, and retention and pad-override controls.

The block moves between four states. BACKUP keeps the main oscillator off, keeps memory in retention and holds every pad group at its safe level. SETTLE restarts the oscillator and waits a fixed number of ticks. RESET holds the core in reset until the reset pin has been low for long enough. NORMAL lets the core run.

Both pins pass through a two-stage synchronizer before the state machine sees them. A pin change therefore acts on the third timer-clock edge after it.

Top module: `bkup_pwr_seq`

## Requirements
- R1: While the block reset is low, and after it, the state is BACKUP. In BACKUP the oscillator enable is 0, the core reset is asserted and all pads are in their safe levels.
- R2: The state output uses these codes: NORMAL=0, RESET=1, BACKUP=2, SETTLE=3. The other outputs follow the state:
  - the oscillator enable is 0 only in BACKUP;
  - the stall is 1 only in SETTLE;
  - the core reset (active low) is released only in NORMAL;
  - the retention enable is 1 in BACKUP and SETTLE.
- R3: From NORMAL or RESET, the block enters BACKUP when both synchronized pins are low. This takes priority over every reset-pulse rule. It happens on the third edge after the pins change.
- R4: In BACKUP and SETTLE the pads are forced to safe levels:
  - every strobe pad is driven 1;
  - every serial and pulse pad is driven 0;
  - every port output enable is 0 (high impedance);
  - the bus output enable is 0 and the bus pull-down is 1.
  In NORMAL and RESET the core values pass through and the pull-down is 0.
- R5: In BACKUP, a high power-enable moves the block to SETTLE. The block stays in SETTLE for exactly SETTLE_TICKS edges and then goes to RESET.
- R6: A low synchronized power-enable during SETTLE returns the block to BACKUP.
- R7: After a wake-up, a release of the reset pin moves the block from RESET to NORMAL only if the pin was seen low for at least POR_TICKS edges, counted from the start of SETTLE. An earlier release is ignored. The block stays in RESET, and a fresh low pulse of full length is then needed.
- R8: In NORMAL, the reset pin seen low for RUN_TICKS consecutive edges moves the block to RESET. A shorter pulse leaves NORMAL undisturbed.
- R9: After an in-operation reset, a release of the reset pin returns the block from RESET to NORMAL.
- R10: A reset pin seen high during SETTLE sets the fault flag. The flag stays set until the block next enters BACKUP, where it clears.
- R11: In NORMAL, a low power-enable with the reset pin high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on timer clock |
| rst_ni | input | 1 | Block reset, asynchronous assert, active low |
| pwr_en_i | input | 1 | Power-enable pin, active high |
| rst_pin_ni | input | 1 | Board reset pin, active low |
| core_stb_i | input | N_STB | Core values for chip-select, strobe and clock-out pads |
| core_ser_i | input | N_SER | Core values for serial transmit and pulse pads |
| core_gpio_oe_i | input | N_GPIO | Core output enables of the general port |
| core_bus_oe_i | input | 1 | Core output enable of the address/data bus |
| osc_en_o | output | 1 | Main oscillator enable |
| stall_o | output | 1 | Clock-settling stall |
| core_rst_no | output | 1 | Core internal reset, active low |
| ret_en_o | output | 1 | Memory retention enable |
| state_o | output | 2 | State code |
| fault_o | output | 1 | Early-release fault flag |
| pad_stb_o | output | N_STB | Strobe pad values |
| pad_ser_o | output | N_SER | Serial and pulse pad values |
| pad_gpio_oe_o | output | N_GPIO | Port output enables at the pads |
| pad_bus_oe_o | output | 1 | Bus output enable at the pads |
| pad_bus_pd_o | output | 1 | Bus pull-down enable |

## Verification
A wrong state code appears at once at every decoded output and at the pads. The same clock edge that changes the state also flips the oscillator enable, the core reset and the pad overrides. A miscounted settle or pulse counter only shows up as a transition one edge early or late. For that reason the boundary tests sample on the exact edge where the state must change, and one edge before it. A fault flag that clears too early is exposed by keeping the flag observed across a full SETTLE, RESET and NORMAL sequence.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_RESET  = 2'd1,
    ST_BACKUP = 2'd2,
    ST_SETTLE = 2'd3
  } bkst_e;
endpackage

// File: rtl/bkup_rst_sync.sv
module bkup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/bkup_sync.sv
module bkup_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  // pins read as low (backup request) until sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bkup_fsm.sv
module bkup_fsm
  import bkup_pkg::*;
#(
  parameter int SETTLE_TICKS = 33,
  parameter int RUN_TICKS    = 4,
  parameter int POR_TICKS    = 3277
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pwr_en_i,
  input  logic  rst_pin_ni,
  output bkst_e state_o,
  output logic  fault_o,
  output logic  osc_en_o,
  output logic  stall_o,
  output logic  core_rst_no,
  output logic  ret_en_o,
  output logic  force_o
);
  localparam int LOW_SAT = (POR_TICKS > RUN_TICKS) ? POR_TICKS : RUN_TICKS;
  localparam int LOW_W   = $clog2(LOW_SAT + 1);
  localparam int SET_W   = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [LOW_W-1:0] LOW_SAT_V  = LOW_W'(LOW_SAT);
  localparam logic [LOW_W-1:0] RUN_V      = LOW_W'(RUN_TICKS);
  localparam logic [LOW_W-1:0] RUN_LAST_V = LOW_W'(RUN_TICKS - 1);
  localparam logic [LOW_W-1:0] POR_V      = LOW_W'(POR_TICKS);
  localparam logic [SET_W-1:0] SET_LAST_V = SET_W'(SETTLE_TICKS - 1);

  bkst_e            state_q, state_d;
  logic [SET_W-1:0] settle_q, settle_d;
  logic [LOW_W-1:0] low_q, low_d;
  logic             por_q, por_d;
  logic             fault_q, fault_d;
  logic             sleep_req;
  logic             release_ok;

  assign sleep_req  = !pwr_en_i && !rst_pin_ni;
  assign release_ok = rst_pin_ni && (low_q >= (por_q ? POR_V : RUN_V));

  // reset-pin low-time counter, saturating
  always_comb begin
    if (state_q == ST_BACKUP || rst_pin_ni) low_d = '0;
    else if (low_q != LOW_SAT_V)            low_d = low_q + 1'b1;
    else                                    low_d = low_q;
  end

  always_comb begin
    state_d  = state_q;
    settle_d = settle_q;
    por_d    = por_q;
    fault_d  = fault_q;
    unique case (state_q)
      ST_BACKUP: begin
        settle_d = '0;
        fault_d  = 1'b0;
        por_d    = 1'b0;
        if (pwr_en_i) state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        settle_d = settle_q + 1'b1;
        if (rst_pin_ni) fault_d = 1'b1;
        if (!pwr_en_i) begin
          state_d = ST_BACKUP;
        end else if (settle_q == SET_LAST_V) begin
          state_d = ST_RESET;
          por_d   = 1'b1;
        end
      end
      ST_RESET: begin
        if (sleep_req) begin
          state_d = ST_BACKUP;
        end else if (release_ok) begin
          state_d = ST_NORMAL;
          por_d   = 1'b0;
        end
      end
      ST_NORMAL: begin
        if (sleep_req)                                state_d = ST_BACKUP;
        else if (!rst_pin_ni && low_q == RUN_LAST_V)  state_d = ST_RESET;
      end
      default: state_d = ST_BACKUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_BACKUP;
      settle_q <= '0;
      low_q    <= '0;
      por_q    <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      low_q   <= low_d;
      por_q   <= por_d;
      fault_q <= fault_d;
      if (state_q == ST_SETTLE || state_q == ST_BACKUP) settle_q <= settle_d;
    end
  end

  assign state_o     = state_q;
  assign fault_o     = fault_q;
  assign osc_en_o    = (state_q != ST_BACKUP);
  assign stall_o     = (state_q == ST_SETTLE);
  assign core_rst_no = (state_q == ST_NORMAL);
  assign ret_en_o    = (state_q == ST_BACKUP) || (state_q == ST_SETTLE);
  assign force_o     = ret_en_o;

  AST_BACKUP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_BACKUP && sleep_req) |=> state_q == ST_BACKUP); // R3
  AST_SETTLE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE && !pwr_en_i) |=> state_q == ST_BACKUP); // R6
  AST_SETTLE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESET && $past(state_q) == ST_SETTLE) |-> $past(settle_q) == SET_LAST_V); // R5
  AST_RELEASE_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORMAL && $past(state_q) == ST_RESET)
      |-> $past(low_q) >= ($past(por_q) ? POR_V : RUN_V)); // R7
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && state_q != ST_BACKUP) |=> fault_q); // R10
endmodule

// File: rtl/bkup_pin_guard.sv
module bkup_pin_guard #(
  parameter int N_STB  = 9,
  parameter int N_SER  = 3,
  parameter int N_GPIO = 16
) (
  input  logic              force_i,
  input  logic [N_STB-1:0]  core_stb_i,
  input  logic [N_SER-1:0]  core_ser_i,
  input  logic [N_GPIO-1:0] core_gpio_oe_i,
  input  logic              core_bus_oe_i,
  output logic [N_STB-1:0]  pad_stb_o,
  output logic [N_SER-1:0]  pad_ser_o,
  output logic [N_GPIO-1:0] pad_gpio_oe_o,
  output logic              pad_bus_oe_o,
  output logic              pad_bus_pd_o
);
  // each group has its own safe level
  assign pad_stb_o     = force_i ? '1 : core_stb_i;
  assign pad_ser_o     = force_i ? '0 : core_ser_i;
  assign pad_gpio_oe_o = force_i ? '0 : core_gpio_oe_i;
  assign pad_bus_oe_o  = !force_i && core_bus_oe_i;
  assign pad_bus_pd_o  = force_i;
endmodule

// File: rtl/bkup_pwr_seq.sv
module bkup_pwr_seq
  import bkup_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SETTLE_TICKS = 33,
  parameter int RUN_TICKS    = 4,
  parameter int POR_TICKS    = 3277,
  parameter int N_STB        = 9,
  parameter int N_SER        = 3,
  parameter int N_GPIO       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_en_i,
  input  logic              rst_pin_ni,
  input  logic [N_STB-1:0]  core_stb_i,
  input  logic [N_SER-1:0]  core_ser_i,
  input  logic [N_GPIO-1:0] core_gpio_oe_i,
  input  logic              core_bus_oe_i,
  output logic              osc_en_o,
  output logic              stall_o,
  output logic              core_rst_no,
  output logic              ret_en_o,
  output logic [1:0]        state_o,
  output logic              fault_o,
  output logic [N_STB-1:0]  pad_stb_o,
  output logic [N_SER-1:0]  pad_ser_o,
  output logic [N_GPIO-1:0] pad_gpio_oe_o,
  output logic              pad_bus_oe_o,
  output logic              pad_bus_pd_o
);
  logic       rst_sync_n;
  logic [1:0] pins_s;
  logic       force_w;
  bkst_e      state_w;

  bkup_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  bkup_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .d_i    ({pwr_en_i, rst_pin_ni}),
    .q_o    (pins_s)
  );

  bkup_fsm #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .RUN_TICKS    (RUN_TICKS),
    .POR_TICKS    (POR_TICKS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .pwr_en_i    (pins_s[1]),
    .rst_pin_ni  (pins_s[0]),
    .state_o     (state_w),
    .fault_o     (fault_o),
    .osc_en_o    (osc_en_o),
    .stall_o     (stall_o),
    .core_rst_no (core_rst_no),
    .ret_en_o    (ret_en_o),
    .force_o     (force_w)
  );

  bkup_pin_guard #(.N_STB(N_STB), .N_SER(N_SER), .N_GPIO(N_GPIO)) u_guard (
    .force_i        (force_w),
    .core_stb_i     (core_stb_i),
    .core_ser_i     (core_ser_i),
    .core_gpio_oe_i (core_gpio_oe_i),
    .core_bus_oe_i  (core_bus_oe_i),
    .pad_stb_o      (pad_stb_o),
    .pad_ser_o      (pad_ser_o),
    .pad_gpio_oe_o  (pad_gpio_oe_o),
    .pad_bus_oe_o   (pad_bus_oe_o),
    .pad_bus_pd_o   (pad_bus_pd_o)
  );

  assign state_o = state_w;

  AST_PADS_SAFE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_w == ST_BACKUP) |-> (&pad_stb_o && pad_ser_o == '0 && pad_gpio_oe_o == '0
                                && !pad_bus_oe_o && pad_bus_pd_o)); // R4
  AST_CLOCK_OFF: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_w == ST_BACKUP) |-> (!osc_en_o && !core_rst_no && ret_en_o)); // R2
endmodule

// File: tb/test_bkup_pwr_seq.sv
module test_bkup_pwr_seq;
  localparam int N_STB  = 4;
  localparam int N_SER  = 3;
  localparam int N_GPIO = 8;
  localparam int NVEC   = 19;
  localparam logic [N_STB-1:0]  CORE_STB  = 4'h5;
  localparam logic [N_SER-1:0]  CORE_SER  = 3'b101;
  localparam logic [N_GPIO-1:0] CORE_GPIO = 8'hA5;

  // vector: {pwr_en, rst_pin_n, ticks[5:0], exp_state[1:0], exp_fault}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 6'd4,  2'd2, 1'b0},  // 0  R1 stays in backup
    {1'b1, 1'b0, 6'd4,  2'd3, 1'b0},  // 1  R5 settling
    {1'b1, 1'b0, 6'd10, 2'd1, 1'b0},  // 2  R5 settle done -> reset
    {1'b1, 1'b1, 6'd5,  2'd1, 1'b0},  // 3  R7 early release ignored
    {1'b1, 1'b0, 6'd24, 2'd1, 1'b0},  // 4  R7 fresh long pulse
    {1'b1, 1'b1, 6'd4,  2'd0, 1'b0},  // 5  R7 qualified release
    {1'b1, 1'b0, 6'd4,  2'd0, 1'b0},  // 6  R8 short pulse begins
    {1'b1, 1'b1, 6'd6,  2'd0, 1'b0},  // 7  R8 4-tick pulse ignored
    {1'b1, 1'b0, 6'd8,  2'd1, 1'b0},  // 8  R8 5-tick pulse -> reset
    {1'b1, 1'b1, 6'd4,  2'd0, 1'b0},  // 9  R9 back to normal
    {1'b0, 1'b1, 6'd6,  2'd0, 1'b0},  // 10 R11 power-enable alone
    {1'b0, 1'b0, 6'd5,  2'd2, 1'b0},  // 11 R3 backup entry
    {1'b1, 1'b1, 6'd6,  2'd3, 1'b1},  // 12 R10 release during settle
    {1'b1, 1'b1, 6'd10, 2'd1, 1'b1},  // 13 R10 sticky
    {1'b1, 1'b0, 6'd24, 2'd1, 1'b1},  // 14 R7 full pulse
    {1'b1, 1'b1, 6'd4,  2'd0, 1'b1},  // 15 R9 normal, fault kept
    {1'b0, 1'b0, 6'd5,  2'd2, 1'b0},  // 16 R10 cleared in backup
    {1'b1, 1'b0, 6'd6,  2'd3, 1'b0},  // 17 R5 settle again
    {1'b0, 1'b0, 6'd5,  2'd2, 1'b0}   // 18 R6 abort to backup
  };

  logic clk = 1'b0;
  logic rst_n, pwr_en, rst_pin_n;
  logic osc_en, stall, core_rst_n, ret_en, fault, bus_oe, bus_pd;
  logic [1:0] state;
  logic [N_STB-1:0]  pad_stb;
  logic [N_SER-1:0]  pad_ser;
  logic [N_GPIO-1:0] pad_gpio;
  int applied = 0;
  int miscomp = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bkup_pwr_seq #(
    .SYNC_STAGES(2), .SETTLE_TICKS(8), .RUN_TICKS(5), .POR_TICKS(20),
    .N_STB(N_STB), .N_SER(N_SER), .N_GPIO(N_GPIO)
  ) i_bkup_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwr_en_i(pwr_en), .rst_pin_ni(rst_pin_n),
    .core_stb_i(CORE_STB), .core_ser_i(CORE_SER), .core_gpio_oe_i(CORE_GPIO),
    .core_bus_oe_i(1'b1),
    .osc_en_o(osc_en), .stall_o(stall), .core_rst_no(core_rst_n), .ret_en_o(ret_en),
    .state_o(state), .fault_o(fault),
    .pad_stb_o(pad_stb), .pad_ser_o(pad_ser), .pad_gpio_oe_o(pad_gpio),
    .pad_bus_oe_o(bus_oe), .pad_bus_pd_o(bus_pd)
  );

  task automatic cmp(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check(input logic [1:0] st, input logic flt, input string req);
    logic frc;
    frc = (st == 2'd2) || (st == 2'd3);
    applied++;
    cmp(req, "state", 16'(state), 16'(st));
    cmp(req, "fault", 16'(fault), 16'(flt));
    cmp("R2", "osc_en", 16'(osc_en), 16'(st != 2'd2));
    cmp("R2", "stall", 16'(stall), 16'(st == 2'd3));
    cmp("R2", "core_rst_n", 16'(core_rst_n), 16'(st == 2'd0));
    cmp("R2", "ret_en", 16'(ret_en), 16'(frc));
    cmp("R4", "pad_stb", 16'(pad_stb), frc ? 16'hF : 16'(CORE_STB));
    cmp("R4", "pad_ser", 16'(pad_ser), frc ? 16'h0 : 16'(CORE_SER));
    cmp("R4", "pad_gpio", 16'(pad_gpio), frc ? 16'h0 : 16'(CORE_GPIO));
    cmp("R4", "bus_oe", 16'(bus_oe), 16'(!frc));
    cmp("R4", "bus_pd", 16'(bus_pd), 16'(frc));
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; pwr_en = 1'b0; rst_pin_n = 1'b0;
    ticks(3);
    check(2'd2, 1'b0, "R1 reset");
    rst_n = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      pwr_en    = VEC[v][10];
      rst_pin_n = VEC[v][9];
      ticks(int'(VEC[v][8:3]));
      check(VEC[v][2:1], VEC[v][0], $sformatf("vector %0d", v));
    end
    // R9 reach normal, then R1 asynchronous reset
    pwr_en = 1'b1; rst_pin_n = 1'b0; ticks(32);
    rst_pin_n = 1'b1; ticks(4);
    check(2'd0, 1'b0, "R9 normal before block reset");
    rst_n = 1'b0; #1;
    check(2'd2, 1'b0, "R1 async reset");
    ticks(2);
    rst_n = 1'b1; ticks(8);
    check(2'd3, 1'b1, "R10 wake with pin high");
    // R5 exact settle length
    pwr_en = 1'b0; rst_pin_n = 1'b0; ticks(5);
    check(2'd2, 1'b0, "R3 backup");
    pwr_en = 1'b1; ticks(10);
    check(2'd3, 1'b0, "R5 last settle tick");
    ticks(1);
    check(2'd1, 1'b0, "R5 settle end");
    // R7 one tick short of the power-on minimum
    ticks(9);
    rst_pin_n = 1'b1; ticks(4);
    check(2'd1, 1'b0, "R7 release one tick early");
    rst_pin_n = 1'b0; ticks(20);
    rst_pin_n = 1'b1; ticks(4);
    check(2'd0, 1'b0, "R7 release at exact minimum");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  end
endmodule